// File: doc/BRIEF.md
# Instrument Status Display Controller

This block turns five status signals of an instrument into the pattern shown on one seven-segment digit and its two decimal points. The digit shows 0 from power-up until a host has connected. After that it shows the unit's 4-bit index in hexadecimal. The left decimal point reports whether the unit is configured. The right decimal point reports the state of the stored vector, using three states: dark, steady, or blinking.

Two small state machines make the decisions. The digit machine has the states `DIG_ZERO` and `DIG_INDEX`. It moves from `DIG_ZERO` to `DIG_INDEX` when the host link flag is high, and moves back when the flag drops. The right-point machine has the states `RDP_OFF`, `RDP_STEADY` and `RDP_BLINK`. Each cycle it picks its next state from the input flags, with playing taking priority over loaded. Entering `RDP_BLINK` from either of the other two states is the *restart* transition. A free-running prescaler sets the blink rate, and the restart transition clears it so that the blink always starts in the lit phase.

All outputs are registered. Each output shows the inputs sampled at the previous rising clock edge, so the latency is one cycle.

Top module: `sdisp_status_ctrl`

## Requirements
- R1: While reset is held, and just after it is released with all inputs low, `seg` is 7'h3F and both decimal points are off.
- R2: While the host link flag is low, `seg` shows 0 (7'h3F) whatever the index input holds.
- R3: One cycle after the link flag is seen high, `seg` shows the index. Bit 0 is segment a and bit 6 is segment g, active high. The codes for 0..F are 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71.
- R4: When the link flag drops, the digit returns to 0 on the following cycle.
- R5: `dp_left` equals the configured flag sampled at the previous edge. It does not change before that edge.
- R6: With both loaded and playing low, `dp_right` stays off.
- R7: With loaded high and playing low, `dp_right` is steadily on.
- R8: While playing is high, `dp_right` is on for BLINK_HALF cycles and then off for BLINK_HALF cycles, repeating.
- R9: On each entry into playing, the blink starts in its on phase, with a full BLINK_HALF on-period, whatever phase the prescaler held before.
- R10: Playing takes priority over loaded: with playing high and loaded low, `dp_right` still blinks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_link | input | 1 | Host software has connected |
| unit_idx | input | 4 | Index assigned to this unit |
| cfg_done | input | 1 | Unit is configured |
| vec_loaded | input | 1 | A vector is stored |
| vec_playing | input | 1 | The vector is being played |
| seg | output | 7 | Segments a (bit 0) to g (bit 6), active high |
| dp_left | output | 1 | Configured indicator |
| dp_right | output | 1 | Vector indicator: off, steady or blinking |

## Verification
The bench walks all sixteen index codes through the encoder. It checks that a non-zero index is hidden until the link is up, so a design that shows the index early fails, as does one that keeps showing it after the link drops. It stops playback in the middle of an off phase and starts it again. A prescaler that was never restarted would then begin dark or give a short first pulse. It also plays with the loaded flag low, which catches a priority encoder that checks loaded first and shows a steady point instead of a blink.

// File: rtl/sdisp_pkg.sv
package sdisp_pkg;

    localparam int NIB_W = 4;
    localparam int SEG_W = 7;

    typedef enum logic [1:0] {
        RDP_OFF    = 2'd0,
        RDP_STEADY = 2'd1,
        RDP_BLINK  = 2'd2
    } rdp_state_e;

    typedef enum logic {
        DIG_ZERO  = 1'b0,
        DIG_INDEX = 1'b1
    } dig_state_e;

    // bit 0 = segment a ... bit 6 = segment g
    function automatic logic [SEG_W-1:0] hex_to_seg(input logic [NIB_W-1:0] nib);
        logic [SEG_W-1:0] s;
        unique case (nib)
            4'h0: s = 7'h3F;
            4'h1: s = 7'h06;
            4'h2: s = 7'h5B;
            4'h3: s = 7'h4F;
            4'h4: s = 7'h66;
            4'h5: s = 7'h6D;
            4'h6: s = 7'h7D;
            4'h7: s = 7'h07;
            4'h8: s = 7'h7F;
            4'h9: s = 7'h6F;
            4'hA: s = 7'h77;
            4'hB: s = 7'h7C;
            4'hC: s = 7'h39;
            4'hD: s = 7'h5E;
            4'hE: s = 7'h79;
            4'hF: s = 7'h71;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sdisp_blink_gen.sv
module sdisp_blink_gen #(
    parameter int BLINK_HALF = 12_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic phase_on
);
    localparam int CW = (BLINK_HALF > 1) ? $clog2(BLINK_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(BLINK_HALF - 1);

    logic [CW-1:0] cnt_q;
    logic          phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= 1'b1;
        end else if (restart) begin
            cnt_q   <= '0;
            phase_q <= 1'b1;
        end else if (cnt_q == LAST) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign phase_on = phase_q;

endmodule

// File: rtl/sdisp_rdp_fsm.sv
module sdisp_rdp_fsm
    import sdisp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic loaded,
    input  logic playing,
    input  logic phase_on,
    output logic restart,
    output logic dp
);
    rdp_state_e state_q, state_d;

    always_comb begin
        if (playing)     state_d = RDP_BLINK;
        else if (loaded) state_d = RDP_STEADY;
        else             state_d = RDP_OFF;
    end

    assign restart = (state_d == RDP_BLINK) && (state_q != RDP_BLINK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RDP_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        dp = 1'b0;
        unique case (state_q)
            RDP_OFF:    dp = 1'b0;
            RDP_STEADY: dp = 1'b1;
            RDP_BLINK:  dp = phase_on;
            default:    dp = 1'b0;
        endcase
    end

endmodule

// File: rtl/sdisp_digit_fsm.sv
module sdisp_digit_fsm
    import sdisp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link,
    input  logic [NIB_W-1:0] idx,
    output logic [SEG_W-1:0] seg
);
    dig_state_e       state_q;
    logic [NIB_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DIG_ZERO;
            idx_q   <= '0;
        end else begin
            unique case (state_q)
                DIG_ZERO:  if (link)  state_q <= DIG_INDEX;
                DIG_INDEX: if (!link) state_q <= DIG_ZERO;
                default:              state_q <= DIG_ZERO;
            endcase
            idx_q <= idx;
        end
    end

    always_comb begin
        seg = hex_to_seg('0);
        unique case (state_q)
            DIG_ZERO:  seg = hex_to_seg('0);
            DIG_INDEX: seg = hex_to_seg(idx_q);
            default:   seg = hex_to_seg('0);
        endcase
    end

endmodule

// File: rtl/sdisp_status_ctrl.sv
module sdisp_status_ctrl
    import sdisp_pkg::*;
#(
    parameter int BLINK_HALF = 12_500_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_link,
    input  logic [NIB_W-1:0] unit_idx,
    input  logic             cfg_done,
    input  logic             vec_loaded,
    input  logic             vec_playing,
    output logic [SEG_W-1:0] seg,
    output logic             dp_left,
    output logic             dp_right
);
    logic restart;
    logic phase_on;
    logic cfg_q;

    sdisp_digit_fsm u_digit (
        .clk   (clk),
        .rst_n (rst_n),
        .link  (host_link),
        .idx   (unit_idx),
        .seg   (seg)
    );

    sdisp_blink_gen #(.BLINK_HALF(BLINK_HALF)) u_blink (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .phase_on (phase_on)
    );

    sdisp_rdp_fsm u_rdp (
        .clk      (clk),
        .rst_n    (rst_n),
        .loaded   (vec_loaded),
        .playing  (vec_playing),
        .phase_on (phase_on),
        .restart  (restart),
        .dp       (dp_right)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= 1'b0;
        else        cfg_q <= cfg_done;
    end

    assign dp_left = cfg_q;

endmodule

// File: rtl/sdisp_status_chk.sv
module sdisp_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_link,
    input logic       cfg_done,
    input logic       vec_loaded,
    input logic       vec_playing,
    input logic [6:0] seg,
    input logic       dp_left,
    input logic       dp_right
);
    logic [1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            age_q <= 2'd0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // R2
    digit_zero_unlinked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0) && !$past(host_link) |-> seg == 7'h3F);

    // R5
    left_dp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0) |-> dp_left == $past(cfg_done));

    // R6
    right_dp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0) && !$past(vec_loaded) && !$past(vec_playing) |-> !dp_right);

    // R7
    right_dp_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0) && $past(vec_loaded) && !$past(vec_playing) |-> dp_right);

    // R9
    blink_restart_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) && $past(vec_playing) && !$past(vec_playing, 2) |-> dp_right);

endmodule

bind sdisp_status_ctrl sdisp_status_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_link   (host_link),
    .cfg_done    (cfg_done),
    .vec_loaded  (vec_loaded),
    .vec_playing (vec_playing),
    .seg         (seg),
    .dp_left     (dp_left),
    .dp_right    (dp_right)
);

// File: tb/tb_sdisp_status_ctrl.sv
module tb_sdisp_status_ctrl;
    localparam int HALF = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_link = 1'b0;
    logic [3:0] unit_idx = 4'h0;
    logic       cfg_done = 1'b0;
    logic       vec_loaded = 1'b0;
    logic       vec_playing = 1'b0;
    logic [6:0] seg;
    logic       dp_left;
    logic       dp_right;

    int n_run = 0;
    int n_fail = 0;
    logic [6:0] seg_tbl [16];

    always #10 clk = ~clk;

    sdisp_status_ctrl #(.BLINK_HALF(HALF)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_link   (host_link),
        .unit_idx    (unit_idx),
        .cfg_done    (cfg_done),
        .vec_loaded  (vec_loaded),
        .vec_playing (vec_playing),
        .seg         (seg),
        .dp_left     (dp_left),
        .dp_right    (dp_right)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // inputs applied at a negedge; the first sample is right after the next edge
    task automatic check_blink(input string req, input int cycles);
        for (int i = 0; i < cycles; i++) begin
            tick();
            check(req, int'(dp_right), int'(((i / HALF) % 2) == 0));
        end
    endtask

    task automatic t_reset();
        check("R1 seg in reset", int'(seg), 'h3F);
        check("R1 dp_left in reset", int'(dp_left), 0);
        check("R1 dp_right in reset", int'(dp_right), 0);
        @(negedge clk);
        rst_n = 1'b1;
        tick();
        check("R1 seg after reset", int'(seg), 'h3F);
        check("R1 dps after reset", int'({dp_left, dp_right}), 0);
    endtask

    task automatic t_unlinked();
        unit_idx = 4'hA;
        tick();
        tick();
        check("R2 index hidden while unlinked", int'(seg), 'h3F);
    endtask

    task automatic t_linked();
        host_link = 1'b1;
        for (int v = 0; v < 16; v++) begin
            unit_idx = v[3:0];
            tick();
            check("R3 hex code", int'(seg), int'(seg_tbl[v]));
        end
    endtask

    task automatic t_unlink();
        unit_idx  = 4'h7;
        tick();
        host_link = 1'b0;
        tick();
        check("R4 digit back to 0", int'(seg), 'h3F);
    endtask

    task automatic t_left_dp();
        cfg_done = 1'b1;
        #1;
        check("R5 no change before edge", int'(dp_left), 0);
        @(negedge clk);
        tick();
        check("R5 dp_left on", int'(dp_left), 1);
        cfg_done = 1'b0;
        tick();
        check("R5 dp_left off", int'(dp_left), 0);
    endtask

    task automatic t_rdp_off();
        vec_loaded = 1'b0;
        vec_playing = 1'b0;
        for (int i = 0; i < 3 * HALF; i++) begin
            tick();
            check("R6 dp_right off", int'(dp_right), 0);
        end
    endtask

    task automatic t_rdp_steady();
        vec_loaded = 1'b1;
        for (int i = 0; i < 3 * HALF; i++) begin
            tick();
            check("R7 dp_right steady", int'(dp_right), 1);
        end
    endtask

    task automatic t_rdp_blink();
        vec_playing = 1'b1;
        check_blink("R8 blink pattern", 4 * HALF);
    endtask

    task automatic t_restart();
        // park the prescaler in the middle of an off phase
        for (int i = 0; i < HALF + 1; i++) tick();
        check("R8 mid off phase", int'(dp_right), 0);
        vec_playing = 1'b0;
        tick();
        check("R7 back to steady", int'(dp_right), 1);
        vec_playing = 1'b1;
        check_blink("R9 restart in on phase", 2 * HALF);
    endtask

    task automatic t_priority();
        vec_playing = 1'b0;
        vec_loaded  = 1'b0;
        tick();
        vec_playing = 1'b1;
        check_blink("R10 playing over loaded", 2 * HALF);
        vec_playing = 1'b0;
        tick();
        check("R6 off after stop", int'(dp_right), 0);
    endtask

    initial begin
        seg_tbl = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                    7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
        repeat (2) @(negedge clk);
        t_reset();
        t_unlinked();
        t_linked();
        t_unlink();
        t_left_dp();
        t_rdp_off();
        t_rdp_steady();
        t_rdp_blink();
        t_restart();
        t_priority();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule